// File: doc/BRIEF.md
# H-Bridge Gate Sequencer with Dead-Time

This block is the synchronous control logic for a full H-bridge built from two half-bridge legs. Each leg has a low-side command and a high-side command. One shared disable line covers both legs. For each leg the block drives two registered gate-enable outputs, one for the lower switch and one for the upper switch. Shoot-through is prevented in two ways. Inside a leg the low-side command takes priority over the high-side command. Every turn-on edge is held back by a programmable count, while every turn-off edge passes through after a single register stage.

A leg whose high-side command is tied high works as a complementary pair. Its low-side command then steers both switches, and dead time is inserted before each switch turns on.

When disable is released, both lower outputs are driven high for a programmable refresh interval. The upper outputs stay off until a separate programmable upper-enable interval has expired. After reset the upper outputs are locked off until disable has been raised once. This mirrors gate drivers whose upper latches must be cleared at power-up. All intervals are cycle counts supplied on configuration inputs that are expected to stay static.

Top module: `hbridge_gate_ctrl`

## Requirements
- R1: While disable is high, every gate output is low from the first clock edge that samples disable high.
- R2: In a leg with its low-side command high, the upper output is low from the next edge, even when the high-side command is also high.
- R3: In steady state with disable low and the lockout cleared, each leg gives lower = low command and upper = high command AND NOT low command. With both commands low, both outputs are off.
- R4: An output whose request is withdrawn goes low at the very next clock edge, with no programmed delay.
- R5: A lower output turns on lo_dly_i+1 edges after its request appears, and an upper output turns on hi_dly_i+1 edges after its request appears. Both legs share these two delays.
- R6: A turn-on count restarts whenever the request drops before the count expires, so a request shorter than the delay never reaches the output.
- R7: A leg with its high-side command held high runs as a complementary pair. Each change of the low command first turns the active switch off at edge 1, then turns the other switch on after its own delay. Neither switch is on during the gap.
- R8: When disable falls (lockout cleared, refresh_len_i = L > 0), both lower outputs are high for exactly L cycles, starting at edge 1 after the fall. After that they follow their commands.
- R9: After a disable fall, no upper output turns on before edge upper_dly_i + hi_dly_i + 2. When upper_dly_i is at least refresh_len_i and the high command is held with the low command off, the upper output turns on at exactly that edge.
- R10: After reset, the upper outputs stay low until disable has gone from low to high at least once. The lower outputs work normally meanwhile.
- R11: The lower and upper outputs of the same leg are never both high.
- R12: During reset all gate outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dis_i | input | 1 | Shared disable, active high |
| lo_cmd_i | input | N_LEGS | Low-side command per leg (bit 0 = leg A, bit 1 = leg B) |
| hi_cmd_i | input | N_LEGS | High-side command per leg |
| lo_dly_i | input | CNT_W | Lower turn-on delay in cycles |
| hi_dly_i | input | CNT_W | Upper turn-on delay in cycles |
| refresh_len_i | input | CNT_W | Lower refresh pulse length in cycles |
| upper_dly_i | input | CNT_W | Upper-enable wait after disable release, in cycles |
| lo_o | output | N_LEGS | Lower gate enable per leg |
| hi_o | output | N_LEGS | Upper gate enable per leg |

## Verification
The assertions assume that the commands and disable are already synchronous to the clock. They also assume that the four delay inputs stay constant while the bridge is running, because a mid-count change would move edges that the timing properties relate. The stimulus changes commands and disable only just after a falling clock edge. It loads the delay inputs only while the bridge is idle with all commands low. The upper-enable wait is always set at least as long as the refresh pulse.

// File: rtl/hb_gate_pkg.sv
package hb_gate_pkg;
  typedef struct packed {
    logic lo;
    logic hi;
  } leg_req_t;
endpackage

// File: rtl/hb_turnon_dly.sv
module hb_turnon_dly #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic             bypass_i,
  input  logic [CNT_W-1:0] dly_i,
  output logic             on_o
);
  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] cnt_q;
  logic             on_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      on_q  <= 1'b0;
    end else if (!req_i) begin
      cnt_q <= '0;
      on_q  <= 1'b0;
    end else if (bypass_i) begin
      cnt_q <= '0;
      on_q  <= 1'b1;
    end else if (!on_q) begin
      if (cnt_q >= dly_i) on_q <= 1'b1;
      else                cnt_q <= cnt_q + ONE;
    end
  end

  assign on_o = on_q;
endmodule

// File: rtl/hb_disable_seq.sv
module hb_disable_seq #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             dis_i,
  input  logic [CNT_W-1:0] refresh_len_i,
  input  logic [CNT_W-1:0] upper_dly_i,
  output logic             refresh_o,
  output logic             upper_ok_o,
  output logic             armed_o
);
  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic             dis_q;
  logic             armed_q;
  logic [CNT_W-1:0] ref_cnt_q;
  logic [CNT_W-1:0] up_cnt_q;
  logic             fall_ev;
  logic             rise_ev;

  assign rise_ev = dis_i && !dis_q;
  // release edge counts only once the upper latches have been cleared
  assign fall_ev = armed_q && dis_q && !dis_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dis_q   <= 1'b1;
      armed_q <= 1'b0;
    end else begin
      dis_q <= dis_i;
      if (rise_ev) armed_q <= 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ref_cnt_q <= '0;
      up_cnt_q  <= '0;
    end else if (dis_i) begin
      ref_cnt_q <= '0;
      up_cnt_q  <= '0;
    end else if (fall_ev) begin
      ref_cnt_q <= (refresh_len_i != '0) ? refresh_len_i - ONE : '0;
      up_cnt_q  <= upper_dly_i;
    end else begin
      if (ref_cnt_q != '0) ref_cnt_q <= ref_cnt_q - ONE;
      if (up_cnt_q  != '0) up_cnt_q  <= up_cnt_q - ONE;
    end
  end

  assign refresh_o  = !dis_i && ((fall_ev && refresh_len_i != '0) || ref_cnt_q != '0);
  assign upper_ok_o = armed_q && !dis_i && !fall_ev && !refresh_o && up_cnt_q == '0;
  assign armed_o    = armed_q;
endmodule

// File: rtl/hb_leg.sv
module hb_leg
  import hb_gate_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             dis_i,
  input  logic             lo_cmd_i,
  input  logic             hi_cmd_i,
  input  logic             refresh_i,
  input  logic             upper_ok_i,
  input  logic [CNT_W-1:0] lo_dly_i,
  input  logic [CNT_W-1:0] hi_dly_i,
  output logic             lo_o,
  output logic             hi_o
);
  leg_req_t req;

  always_comb begin
    req.lo = !dis_i && (lo_cmd_i || refresh_i);
    // low command wins; upper also waits for the disable sequencer
    req.hi = !dis_i && hi_cmd_i && !lo_cmd_i && !refresh_i && upper_ok_i;
  end

  hb_turnon_dly #(.CNT_W(CNT_W)) u_lo_dly (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .req_i   (req.lo),
    .bypass_i(refresh_i),
    .dly_i   (lo_dly_i),
    .on_o    (lo_o)
  );

  hb_turnon_dly #(.CNT_W(CNT_W)) u_hi_dly (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .req_i   (req.hi),
    .bypass_i(1'b0),
    .dly_i   (hi_dly_i),
    .on_o    (hi_o)
  );
endmodule

// File: rtl/hbridge_gate_ctrl.sv
module hbridge_gate_ctrl #(
  parameter int unsigned N_LEGS = 2,
  parameter int unsigned CNT_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              dis_i,
  input  logic [N_LEGS-1:0] lo_cmd_i,
  input  logic [N_LEGS-1:0] hi_cmd_i,
  input  logic [CNT_W-1:0]  lo_dly_i,
  input  logic [CNT_W-1:0]  hi_dly_i,
  input  logic [CNT_W-1:0]  refresh_len_i,
  input  logic [CNT_W-1:0]  upper_dly_i,
  output logic [N_LEGS-1:0] lo_o,
  output logic [N_LEGS-1:0] hi_o
);
  logic refresh;
  logic upper_ok;
  logic upper_armed;

  hb_disable_seq #(.CNT_W(CNT_W)) u_dis_seq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .dis_i        (dis_i),
    .refresh_len_i(refresh_len_i),
    .upper_dly_i  (upper_dly_i),
    .refresh_o    (refresh),
    .upper_ok_o   (upper_ok),
    .armed_o      (upper_armed)
  );

  for (genvar g = 0; g < N_LEGS; g++) begin : g_leg
    hb_leg #(.CNT_W(CNT_W)) u_leg (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .dis_i     (dis_i),
      .lo_cmd_i  (lo_cmd_i[g]),
      .hi_cmd_i  (hi_cmd_i[g]),
      .refresh_i (refresh),
      .upper_ok_i(upper_ok),
      .lo_dly_i  (lo_dly_i),
      .hi_dly_i  (hi_dly_i),
      .lo_o      (lo_o[g]),
      .hi_o      (hi_o[g])
    );
  end
endmodule

// File: rtl/hbridge_gate_ctrl_chk.sv
module hbridge_gate_ctrl_chk #(
  parameter int unsigned N_LEGS = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              dis_i,
  input logic [N_LEGS-1:0] lo_cmd_i,
  input logic [N_LEGS-1:0] hi_cmd_i,
  input logic [N_LEGS-1:0] lo_o,
  input logic [N_LEGS-1:0] hi_o,
  input logic              refresh_i,
  input logic              armed_i
);
  assert_dis_all_off_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dis_i |=> (lo_o == '0 && hi_o == '0));

  assert_refresh_lo_on_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    refresh_i |=> (lo_o == '1));

  for (genvar g = 0; g < N_LEGS; g++) begin : g_leg
    assert_no_shoot_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(lo_o[g] && hi_o[g]));

    assert_lo_priority_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      lo_cmd_i[g] |=> !hi_o[g]);

    assert_hi_needs_cmd_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(hi_o[g]) |-> $past(hi_cmd_i[g] && !lo_cmd_i[g] && !dis_i));

    assert_lo_fast_off_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!lo_cmd_i[g] && !refresh_i) |=> !lo_o[g]);

    assert_upper_lockout_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(hi_o[g]) |-> $past(armed_i));
  end
endmodule

bind hbridge_gate_ctrl hbridge_gate_ctrl_chk #(.N_LEGS(N_LEGS)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .dis_i    (dis_i),
  .lo_cmd_i (lo_cmd_i),
  .hi_cmd_i (hi_cmd_i),
  .lo_o     (lo_o),
  .hi_o     (hi_o),
  .refresh_i(refresh),
  .armed_i  (upper_armed)
);

// File: tb/hbridge_gate_ctrl_bench.sv
module hbridge_gate_ctrl_bench;
  localparam int N_LEGS = 2;
  localparam int CNT_W  = 8;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              dis_i = 1'b0;
  logic [N_LEGS-1:0] lo_cmd_i = '0;
  logic [N_LEGS-1:0] hi_cmd_i = '0;
  logic [CNT_W-1:0]  lo_dly_i = 8'd3;
  logic [CNT_W-1:0]  hi_dly_i = 8'd2;
  logic [CNT_W-1:0]  refresh_len_i = 8'd3;
  logic [CNT_W-1:0]  upper_dly_i = 8'd6;
  logic [N_LEGS-1:0] lo_o;
  logic [N_LEGS-1:0] hi_o;

  int n_chk = 0;
  int n_bad = 0;
  int overlap = 0;
  bit done = 1'b0;

  always #5 clk_i = ~clk_i;

  hbridge_gate_ctrl #(.N_LEGS(N_LEGS), .CNT_W(CNT_W)) u_hbridge_gate_ctrl (.*);

  always @(negedge clk_i)
    if (rst_ni && ((lo_o & hi_o) != '0)) overlap++;

  task automatic tick(int n = 1);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic chk(string req, int got, int exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  // ticks until the chosen output goes high (sel 0 = lower, 1 = upper)
  task automatic measure(int sel, int leg, output int n);
    n = 0;
    do begin
      tick();
      n++;
    end while (((sel == 0) ? lo_o[leg] : hi_o[leg]) == 1'b0 && n < 40);
  endtask

  task automatic t_reset();
    tick(3);
    chk("R12 lo_o in reset", int'(lo_o), 0);
    chk("R12 hi_o in reset", int'(hi_o), 0);
    rst_ni = 1'b1;
  endtask

  task automatic t_lockout();
    hi_cmd_i = 2'b11;
    tick(30);
    chk("R10 upper locked before disable toggle", int'(hi_o), 0);
    lo_cmd_i = 2'b01;
    tick(10);
    chk("R10 lower usable while locked", int'(lo_o), 1);
    lo_cmd_i = '0;
    hi_cmd_i = '0;
    tick(5);
  endtask

  task automatic t_release();
    int lo_hist[13];
    int hi_hist[13];
    hi_cmd_i = 2'b11;
    dis_i = 1'b1;
    tick(3);
    chk("R1 outputs off under disable", int'({lo_o, hi_o}), 0);
    dis_i = 1'b0;
    for (int t = 1; t <= 12; t++) begin
      tick();
      lo_hist[t] = int'(lo_o);
      hi_hist[t] = int'(hi_o);
    end
    for (int t = 1; t <= 3; t++) chk("R8 refresh high", lo_hist[t], 3);
    chk("R8 refresh ends after L cycles", lo_hist[4], 0);
    chk("R9 upper still off at edge U+Dh+1", hi_hist[9], 0);
    chk("R9 upper on at edge U+Dh+2", hi_hist[10], 3);
    hi_cmd_i = '0;
    tick(5);
  endtask

  task automatic t_latency();
    int n;
    lo_cmd_i = 2'b01;
    measure(0, 0, n);
    chk("R5 lower turn-on latency", n, 4);
    lo_cmd_i = '0;
    tick();
    chk("R4 lower off next edge", int'(lo_o[0]), 0);
    hi_cmd_i = 2'b01;
    measure(1, 0, n);
    chk("R5 upper turn-on latency", n, 3);
    hi_cmd_i = '0;
    tick();
    chk("R4 upper off next edge", int'(hi_o[0]), 0);
    lo_dly_i = 8'd0;
    lo_cmd_i = 2'b10;
    measure(0, 1, n);
    chk("R5 zero lower delay leg B", n, 1);
    lo_cmd_i = '0;
    tick(3);
    lo_dly_i = 8'd3;
  endtask

  task automatic t_priority();
    hi_cmd_i = 2'b01;
    tick(10);
    chk("R2 upper on before low cmd", int'(hi_o[0]), 1);
    lo_cmd_i = 2'b01;
    tick();
    chk("R2 low cmd kills upper at edge 1", int'(hi_o[0]), 0);
    tick(10);
    chk("R2 lower on with both cmds high", int'({lo_o[0], hi_o[0]}), 2);
    lo_cmd_i = '0;
    hi_cmd_i = '0;
    tick(5);
  endtask

  task automatic t_complement();
    int n;
    hi_cmd_i = 2'b11;
    tick(10);
    lo_cmd_i = 2'b01;
    tick();
    chk("R7 gap after lo rise", int'({lo_o[0], hi_o[0]}), 0);
    measure(0, 0, n);
    chk("R7 lower on after dead time", n + 1, 4);
    chk("R7 other leg untouched", int'(hi_o[1]), 1);
    lo_cmd_i = '0;
    tick();
    chk("R7 gap after lo fall", int'({lo_o[0], hi_o[0]}), 0);
    measure(1, 0, n);
    chk("R7 upper on after dead time", n + 1, 3);
    hi_cmd_i = '0;
    tick(5);
  endtask

  task automatic t_glitch();
    int seen = 0;
    int n;
    for (int k = 0; k < 2; k++) begin
      lo_cmd_i = 2'b01;
      tick(); seen |= int'(lo_o[0]);
      tick(); seen |= int'(lo_o[0]);
      lo_cmd_i = '0;
      tick(); seen |= int'(lo_o[0]);
    end
    for (int k = 0; k < 8; k++) begin
      tick(); seen |= int'(lo_o[0]);
    end
    chk("R6 short pulse suppressed", seen, 0);
    lo_cmd_i = 2'b01;
    tick(2);
    lo_cmd_i = '0;
    tick();
    lo_cmd_i = 2'b01;
    measure(0, 0, n);
    chk("R6 count restarts", n, 4);
    lo_cmd_i = '0;
    tick(5);
  endtask

  task automatic t_dis_mid();
    lo_cmd_i = 2'b01;
    hi_cmd_i = 2'b10;
    tick(12);
    chk("R3 mixed legs before disable", int'({lo_o, hi_o}), 6'b0110 & 4'hF);
    dis_i = 1'b1;
    tick();
    chk("R1 disable clears at edge 1", int'({lo_o, hi_o}), 0);
    lo_cmd_i = '0;
    hi_cmd_i = '0;
    tick(3);
  endtask

  task automatic t_truth();
    for (int d = 1; d >= 0; d--) begin
      dis_i = d[0];
      for (int c = 0; c < 16; c++) begin
        lo_cmd_i = c[1:0];
        hi_cmd_i = c[3:2];
        tick(25);
        for (int g = 0; g < N_LEGS; g++) begin
          chk("R3 truth lower", int'(lo_o[g]), d ? 0 : int'(c[g]));
          chk("R3 truth upper", int'(hi_o[g]), d ? 0 : int'(c[g+2] & ~c[g]));
        end
      end
    end
    lo_cmd_i = '0;
    hi_cmd_i = '0;
    tick(5);
  endtask

  initial begin
    t_reset();
    t_lockout();
    t_release();
    t_latency();
    t_priority();
    t_complement();
    t_glitch();
    t_dis_mid();
    t_truth();
    chk("R11 no leg overlap seen", overlap, 0);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got %0d expected %0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule